// File: doc/BRIEF.md
# Token-Based Event Readout Scheduler

This block sits at the head of a token-passing dataway that links a chain of digitizer modules. Each level-1 trigger adds one event that the modules hold and that must be read out. The scheduler keeps a count of these waiting events in an up/down counter. When at least one event is waiting and the dataway is free, it sends out a token. The module that holds the token places its data words on the dataway, marked by a valid flag.

The scheduler accepts words only while a token is out. It counts the accepted words against the fixed event length and writes each word to an output FIFO port. The first and last words of every event carry flag bits. After the last word, the scheduler waits for the token to come back from the end of the chain. Once it returns, the scheduler either goes idle or issues the next token at once.

The controller has four states:
- `ST_IDLE`: no transfer is running.
- `ST_GRANT`: the one cycle in which the token is driven.
- `ST_XFER`: words are being collected.
- `ST_DRAIN`: all words are in and the token has not yet returned.

The transitions are:
- idle→grant: a trigger arrives, or an event is already waiting.
- grant→xfer: the token has been driven and the event is not yet complete.
- grant→drain and xfer→drain: the last word of the event is accepted.
- drain→grant: the token returns and work remains.
- drain→idle: the token returns and nothing is waiting.

Top module: `evx_token_ctrl`

## Requirements
- R1: After reset, `token_out`, `busy`, `fifo_wr` and `ovf_err` are all 0.
- R2: A trigger seen in the idle state drives `token_out` high for exactly one cycle, in the cycle after the trigger. From that cycle on, `busy` is 1.
- R3: The waiting-event count rises by one for each `l1_trig` and falls by one each time an event's last word is accepted. Each counted event produces exactly one token. When the count is zero and the token returns, the block goes idle.
- R4: A word is accepted only in a cycle where `din_valid` is 1 and the token is out, which means the grant cycle or a collection cycle. At all other times `din_valid` is ignored: it causes no FIFO write, and a cycle with `din_valid` low is not counted as a word.
- R5: Each accepted word appears on the FIFO port in the next cycle, with `fifo_wr` high. The fields are: `fifo_data[WORD_W-1:0]` holds the word, bit `WORD_W` is the last-word flag, and bit `WORD_W+1` is the first-word flag.
- R6: A transfer ends after exactly `EVENT_WORDS` accepted words. `busy` stays 1 and no token is driven until `tok_ret` is seen.
- R7: A trigger that arrives during a transfer or while draining causes a new token in the cycle after `tok_ret`. This also holds for a trigger in the same cycle as `tok_ret`.
- R8: `tok_ret` has no effect outside the drain state.
- R9: If a trigger and the acceptance of an event's last word fall in the same cycle, the count stays the same. Exactly one further token follows.
- R10: A trigger that arrives when the count is at its maximum, `2^PEND_W-1`, leaves the count unchanged and sets `ovf_err`. `ovf_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_trig | input | 1 | Level-1 trigger strobe, one cycle per event |
| din | input | WORD_W | Data word from the dataway |
| din_valid | input | 1 | `din` carries a word |
| tok_ret | input | 1 | Token has come back from the end of the chain |
| token_out | output | 1 | One-cycle token issued into the chain |
| busy | output | 1 | A transfer is in progress (grant, collect or drain) |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | WORD_W+2 | {first flag, last flag, word} |
| ovf_err | output | 1 | Sticky flag: the waiting-event count overflowed |

## Verification
A small configuration is used: 4 words per event and a 2-bit waiting count.

- **Trigger sweep.** The main sweep places a second trigger at every word slot of a running event, in the drain state, and on the token-return cycle. This separates four outcomes:
  - a scheduler that forgets a trigger arriving mid-transfer;
  - a scheduler that mishandles the coincidence with the last word;
  - a scheduler that ignores a trigger arriving with the token return;
  - a correct scheduler.
- **Stray inputs.** Valid words while idle or draining, gaps in `din_valid`, and an early token return check that only granted, valid words count.
- **Saturation.** A burst of four triggers fills the counter. It checks that saturation loses no counted event, raises the sticky flag, and that reset clears it.

// File: rtl/evx_pkg.sv
package evx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_XFER  = 2'd2,
        ST_DRAIN = 2'd3
    } xfer_state_t;
endpackage

// File: rtl/evx_pending_ctr.sv
module evx_pending_ctr #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic ovf_err
);
    localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] cnt_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            unique case ({inc, dec})
                2'b10: begin
                    if (cnt_q == CNT_MAX) err_q <= 1'b1;
                    else                  cnt_q <= cnt_q + 1'b1;
                end
                2'b01: begin
                    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign nonzero = (cnt_q != '0);
    assign ovf_err = err_q;
endmodule

// File: rtl/evx_word_track.sv
module evx_word_track #(
    parameter int WORD_W      = 16,
    parameter int EVENT_WORDS = 2304
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [WORD_W-1:0] din,
    output logic              ev_done,
    output logic              wr_q,
    output logic [WORD_W+1:0] data_q
);
    localparam int CNT_W = (EVENT_WORDS > 1) ? $clog2(EVENT_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(EVENT_WORDS - 1);

    logic [CNT_W-1:0] idx_q;
    logic             is_first;
    logic             is_last;

    assign is_first = (idx_q == '0);
    assign is_last  = (idx_q == LAST_IDX);
    assign ev_done  = take && is_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wr_q   <= 1'b0;
            data_q <= '0;
        end else begin
            wr_q <= take;
            if (take) begin
                data_q <= {is_first, is_last, din};
                idx_q  <= is_last ? '0 : idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/evx_seq_fsm.sv
module evx_seq_fsm
    import evx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic pend_nz,
    input  logic ev_done,
    input  logic tok_ret,
    output logic token_out,
    output logic busy,
    output logic take_en
);
    xfer_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pend_nz || trig) state_d = ST_GRANT;
            ST_GRANT: state_d = ev_done ? ST_DRAIN : ST_XFER;
            ST_XFER:  if (ev_done) state_d = ST_DRAIN;
            ST_DRAIN: if (tok_ret) state_d = (pend_nz || trig) ? ST_GRANT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        token_out = 1'b0;
        busy      = 1'b1;
        take_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_GRANT: begin token_out = 1'b1; take_en = 1'b1; end
            ST_XFER:  take_en = 1'b1;
            ST_DRAIN: ;
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/evx_token_ctrl.sv
module evx_token_ctrl #(
    parameter int WORD_W      = 16,
    parameter int EVENT_WORDS = 2304,
    parameter int PEND_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1_trig,
    input  logic [WORD_W-1:0] din,
    input  logic              din_valid,
    input  logic              tok_ret,
    output logic              token_out,
    output logic              busy,
    output logic              fifo_wr,
    output logic [WORD_W+1:0] fifo_data,
    output logic              ovf_err
);
    logic pend_nz;
    logic ev_done;
    logic take_en;
    logic take;

    assign take = take_en && din_valid;

    evx_pending_ctr #(.PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (l1_trig),
        .dec     (ev_done),
        .nonzero (pend_nz),
        .ovf_err (ovf_err)
    );

    evx_word_track #(.WORD_W(WORD_W), .EVENT_WORDS(EVENT_WORDS)) u_words (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .din     (din),
        .ev_done (ev_done),
        .wr_q    (fifo_wr),
        .data_q  (fifo_data)
    );

    evx_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (l1_trig),
        .pend_nz   (pend_nz),
        .ev_done   (ev_done),
        .tok_ret   (tok_ret),
        .token_out (token_out),
        .busy      (busy),
        .take_en   (take_en)
    );
endmodule

// File: rtl/evx_token_ctrl_chk.sv
module evx_token_ctrl_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         token_out,
    input logic         busy,
    input logic         fifo_wr,
    input logic [W+1:0] fifo_data,
    input logic         ovf_err,
    input logic         tok_ret
);
    p_token_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out);

    p_token_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |-> busy);

    p_write_in_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(busy));

    p_flags_with_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_data[W+1] || fifo_data[W]) && $past(fifo_wr) |-> $past(busy));

    p_release_on_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tok_ret));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
endmodule

bind evx_token_ctrl evx_token_ctrl_chk #(.W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .token_out (token_out),
    .busy      (busy),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .ovf_err   (ovf_err),
    .tok_ret   (tok_ret)
);

// File: tb/tb_evx_token_ctrl.sv
module tb_evx_token_ctrl;
    localparam int W  = 16;
    localparam int N  = 4;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l1_trig = 1'b0;
    logic [W-1:0]  din = '0;
    logic          din_valid = 1'b0;
    logic          tok_ret = 1'b0;
    logic          token_out, busy, fifo_wr, ovf_err;
    logic [W+1:0]  fifo_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    evx_token_ctrl #(.WORD_W(W), .EVENT_WORDS(N), .PEND_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .l1_trig(l1_trig), .din(din),
        .din_valid(din_valid), .tok_ret(tok_ret), .token_out(token_out),
        .busy(busy), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .ovf_err(ovf_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic pulse_trig;
        l1_trig = 1'b1;
        tick();
        l1_trig = 1'b0;
    endtask

    // Called in the grant cycle; drives one full event.
    task automatic serve(input logic [W-1:0] base, input int trig_at, input bit gaps);
        for (int i = 0; i < N; i++) begin
            if (gaps && i == 1) begin
                din_valid = 1'b0;
                din = 16'hdead;
                tick();
                chk("R4 gap not written", fifo_wr, 0);
            end
            din = base + W'(i);
            din_valid = 1'b1;
            l1_trig = (i == trig_at);
            tick();
            chk("R5 write strobe", fifo_wr, 1);
            chk("R5 word and flags", fifo_data, {i == 0, i == N - 1, base + W'(i)});
        end
        din_valid = 1'b0;
        l1_trig = 1'b0;
        chk("R6 busy while draining", busy, 1);
        chk("R6 no token while draining", token_out, 0);
    endtask

    task automatic ret(input bit exp_tok, input bit with_trig, input string req);
        tok_ret = 1'b1;
        l1_trig = with_trig;
        tick();
        tok_ret = 1'b0;
        l1_trig = 1'b0;
        chk(req, token_out, exp_tok);
        chk(req, busy, exp_tok);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R1 token reset", token_out, 0);
        chk("R1 busy reset", busy, 0);
        chk("R1 fifo_wr reset", fifo_wr, 0);
        chk("R1 ovf_err reset", ovf_err, 0);
        rst_n = 1'b1;
        tick();

        // R4: valid words while idle are ignored
        din_valid = 1'b1;
        din = 16'h5a5a;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 idle word ignored", fifo_wr, 0);
            chk("R4 idle stays idle", busy, 0);
        end
        din_valid = 1'b0;

        // R2, R5, R6: single event
        pulse_trig();
        chk("R2 token after trigger", token_out, 1);
        chk("R2 busy after trigger", busy, 1);
        serve(16'h0100, -1, 1'b0);
        din_valid = 1'b1;
        tick();
        din_valid = 1'b0;
        chk("R4 drain word ignored", fifo_wr, 0);
        chk("R6 still waiting for return", busy, 1);
        ret(1'b0, 1'b0, "R3 idle after last event");

        // R8: early token return ignored; R4 gap
        pulse_trig();
        chk("R2 token", token_out, 1);
        tok_ret = 1'b1;
        tick();
        tok_ret = 1'b0;
        chk("R8 early return keeps busy", busy, 1);
        chk("R8 early return no token", token_out, 0);
        serve(16'h0200, -1, 1'b1);
        ret(1'b0, 1'b0, "R8 idle after proper return");

        // R7 and R9 sweep over trigger position
        for (int p = 0; p < 6; p++) begin
            pulse_trig();
            chk("R2 token in sweep", token_out, 1);
            serve(W'(16'h1000 + p * 16'h10), (p < N) ? p : -1, 1'b0);
            if (p == N) begin
                pulse_trig();
                chk("R7 no token before return", token_out, 0);
            end
            ret(1'b1, p == 5, (p == N - 1) ? "R9 second token after coincidence" : "R7 second token after return");
            serve(W'(16'h2000 + p * 16'h10), -1, 1'b0);
            ret(1'b0, 1'b0, "R3 idle after queued event");
        end

        // R10: saturation of the waiting count
        pulse_trig();
        pulse_trig();
        pulse_trig();
        chk("R10 no error at maximum", ovf_err, 0);
        pulse_trig();
        chk("R10 error on overflow", ovf_err, 1);
        serve(16'h3000, -1, 1'b0);
        ret(1'b1, 1'b0, "R3 second of three");
        serve(16'h3100, -1, 1'b0);
        ret(1'b1, 1'b0, "R3 third of three");
        serve(16'h3200, -1, 1'b0);
        ret(1'b0, 1'b0, "R10 saturated count drains to idle");
        chk("R10 error sticky", ovf_err, 1);
        tick();
        chk("R10 error still sticky", ovf_err, 1);
        rst_n = 1'b0;
        tick();
        chk("R1 reset clears error", ovf_err, 0);
        rst_n = 1'b1;
        tick();

        summary();
        $finish;
    end
endmodule